// File: doc/BRIEF.md
# Source-Routed Burst Crossbar

This block is a non-blocking switch with NPORT full-duplex ports (16 by default). It moves variable-length bursts of flits from any input to any output. Each flit is a DATA_W-bit payload (36 bits by default), a CTRL_W-bit control field (4 bits by default) and a one-bit end-of-burst marker. The sender puts the target port in the control field of the first flit of a burst. The crossbar latches that target for the whole burst. On the way out it overwrites the control field with the number of the input the burst came from, so the receiver can tell who sent it.

Every input has a one-flit register stage. Every output has its own round-robin arbiter and a registered output stage. Once an input wins an output, that output stays with the input until the end-of-burst flit has moved across. Both sides use valid/ready handshakes. A stalled output stalls the input that owns it, and no flit is lost. Traffic between unrelated input/output pairs moves in parallel, at one flit per cycle per pair.

Top module: `burst_xbar`

## Requirements
- R1: After a synchronous active-high reset, every out_valid is 0 and every in_ready is 1.
- R2: A flit accepted on an input with no contention and a ready output appears on its output two clock edges later, with its payload and end-of-burst bit unchanged.
- R3: The control field of every flit leaving output o holds the number of the input it came from, zero-extended to CTRL_W bits.
- R4: The target of a burst is the first flit's control value modulo NPORT. The control field of every later flit in the same burst has no effect on where that flit goes.
- R5: Once an output has started a burst, it carries only flits from that burst's input until the flit with the end-of-burst bit set has left it.
- R6: When several inputs compete for a free output, the output scans for a requester starting at its pointer, which is 0 after reset. After an end-of-burst flit from input w crosses, the pointer moves to (w+1) modulo NPORT. The pointer does not move at any other time.
- R7: Bursts on disjoint input/output pairs proceed at the same time, with each pair carrying one flit per cycle when its output is ready.
- R8: While out_valid is 1 and out_ready is 0, that output holds its flit unchanged. An input whose register stage is full and cannot move on shows in_ready 0. No flit is dropped or duplicated.
- R9: Flits from one input leave in the order they were accepted.
- R10: A single-flit burst, with the end-of-burst bit set on its first flit, is routed and releases its output like any other burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NPORT | Per-input flit valid |
| in_ready | output | NPORT | Per-input flit accepted this cycle |
| in_data | input | NPORT*DATA_W | Per-input payload, input i at bits i*DATA_W upward |
| in_ctrl | input | NPORT*CTRL_W | Per-input control field (target on first flit) |
| in_tail | input | NPORT | Per-input end-of-burst bit |
| out_valid | output | NPORT | Per-output flit valid |
| out_ready | input | NPORT | Per-output sink ready |
| out_data | output | NPORT*DATA_W | Per-output payload |
| out_ctrl | output | NPORT*CTRL_W | Per-output control field (source input number) |
| out_tail | output | NPORT | Per-output end-of-burst bit |

## Verification
The bench builds the crossbar with four ports, a 36-bit payload and a 4-bit control field. This keeps every arbitration pointer position and every wrap of the round-robin scan within reach in a few hundred cycles. With four ports, control values 4 to 15 exercise the modulo reduction of the target. Separate phases use single-flit bursts, a full permutation at full rate, all inputs aimed at one output, and heavy random backpressure. In every phase the later flits of a burst carry random control values.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  // Per-lane burst state, shared by ingress stages and output arbiters.
  typedef enum logic {
    LANE_IDLE = 1'b0,
    LANE_BUSY = 1'b1
  } lane_e;

  // Number of bits needed to name one of n ports (never less than one).
  function automatic int unsigned port_idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/xbar_ingress.sv
module xbar_ingress
  import xbar_pkg::*;
#(
  parameter int NPORT  = 16,
  parameter int DATA_W = 36,
  parameter int CTRL_W = 4,
  parameter int DEST_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CTRL_W-1:0] in_ctrl,
  input  logic              in_tail,
  output logic              in_ready,
  input  logic              pop,
  output logic              buf_valid,
  output logic [DATA_W-1:0] buf_data,
  output logic              buf_tail,
  output logic [DEST_W-1:0] buf_dest
);

  localparam logic [CTRL_W:0] NP_C = (CTRL_W+1)'(NPORT);

  lane_e       lane_q;
  logic        fire;
  logic [CTRL_W:0] dest_full;

  assign in_ready  = !buf_valid || pop;
  assign fire      = in_valid && in_ready;
  assign dest_full = {1'b0, in_ctrl} % NP_C;

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_valid <= 1'b0;
      buf_data  <= '0;
      buf_tail  <= 1'b0;
      buf_dest  <= '0;
      lane_q    <= LANE_IDLE;
    end else begin
      if (fire) begin
        buf_valid <= 1'b1;
        buf_data  <= in_data;
        buf_tail  <= in_tail;
        if (lane_q == LANE_IDLE) buf_dest <= DEST_W'(dest_full);
        lane_q <= in_tail ? LANE_IDLE : LANE_BUSY;
      end else if (pop) begin
        buf_valid <= 1'b0;
      end
    end
  end

  // R8: a parked flit stays put until the switch takes it
  p_ibuf_hold_r8: assert property (@(posedge clk) disable iff (rst)
    buf_valid && !pop |=> buf_valid && $stable(buf_data) && $stable(buf_tail));

  // R4: a non-first flit never retargets its burst
  p_dest_kept_r4: assert property (@(posedge clk) disable iff (rst)
    fire && (lane_q == LANE_BUSY) |=> $stable(buf_dest));

  // R9: the switch only drains a stage that holds a flit
  p_pop_needs_flit_r9: assert property (@(posedge clk) disable iff (rst)
    pop |-> buf_valid);

endmodule

// File: rtl/xbar_rr_arb.sv
module xbar_rr_arb
  import xbar_pkg::*;
#(
  parameter int NPORT  = 16,
  parameter int DEST_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPORT-1:0]  req,
  input  logic              take,
  input  logic              take_tail,
  output logic [DEST_W-1:0] grant_idx,
  output logic              grant_ok
);

  localparam logic [DEST_W:0] NP_W = (DEST_W+1)'(NPORT);

  lane_e             hold_q;
  logic [DEST_W-1:0] owner_q;
  logic [DEST_W-1:0] ptr_q;
  logic [DEST_W-1:0] rr_idx;
  logic              rr_ok;

  function automatic logic [DEST_W-1:0] wrap_add(input logic [DEST_W-1:0] base,
                                                 input int unsigned k);
    logic [DEST_W:0] s;
    s = {1'b0, base} + (DEST_W+1)'(k);
    if (s >= NP_W) s = s - NP_W;
    return DEST_W'(s);
  endfunction

  // Lowest offset from the pointer wins: scan from the far end downward.
  always_comb begin
    rr_ok  = 1'b0;
    rr_idx = ptr_q;
    for (int k = NPORT - 1; k >= 0; k--) begin
      if (req[wrap_add(ptr_q, k)]) begin
        rr_ok  = 1'b1;
        rr_idx = wrap_add(ptr_q, k);
      end
    end
  end

  always_comb begin
    if (hold_q == LANE_BUSY) begin
      grant_idx = owner_q;
      grant_ok  = req[owner_q];
    end else begin
      grant_idx = rr_idx;
      grant_ok  = rr_ok;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= LANE_IDLE;
      owner_q <= '0;
      ptr_q   <= '0;
    end else if (take) begin
      if (take_tail) begin
        hold_q <= LANE_IDLE;
        ptr_q  <= wrap_add(grant_idx, 1);
      end else begin
        hold_q  <= LANE_BUSY;
        owner_q <= grant_idx;
      end
    end
  end

  // R6: the fairness pointer only moves when a burst ends
  p_ptr_still_r6: assert property (@(posedge clk) disable iff (rst)
    !(take && take_tail) |=> $stable(ptr_q));

  // R7: the output stage only loads when a requester was granted
  p_take_granted_r7: assert property (@(posedge clk) disable iff (rst)
    take |-> grant_ok);

endmodule

// File: rtl/xbar_egress.sv
module xbar_egress #(
  parameter int NPORT  = 16,
  parameter int DATA_W = 36,
  parameter int CTRL_W = 4,
  parameter int DEST_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NPORT*DATA_W-1:0] src_data,
  input  logic [NPORT-1:0]        src_tail,
  input  logic [DEST_W-1:0]       grant_idx,
  input  logic                    grant_ok,
  output logic                    take,
  output logic                    take_tail,
  input  logic                    out_ready,
  output logic                    out_valid,
  output logic [DATA_W-1:0]       out_data,
  output logic [CTRL_W-1:0]       out_ctrl,
  output logic                    out_tail
);

  logic [DATA_W-1:0] sel_data;
  logic              sel_tail;

  always_comb begin
    sel_data = '0;
    sel_tail = 1'b0;
    for (int i = 0; i < NPORT; i++) begin
      if (grant_idx == DEST_W'(i)) begin
        sel_data = src_data[i*DATA_W +: DATA_W];
        sel_tail = src_tail[i];
      end
    end
  end

  assign take      = grant_ok && (!out_valid || out_ready);
  assign take_tail = take && sel_tail;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ctrl  <= '0;
      out_tail  <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= sel_data;
      out_ctrl  <= CTRL_W'(grant_idx);
      out_tail  <= sel_tail;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // Observation of the port: burst in progress and its source.
  logic              mid_q;
  logic [CTRL_W-1:0] src_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      mid_q <= 1'b0;
      src_q <= '0;
    end else if (out_valid && out_ready) begin
      mid_q <= !out_tail;
      src_q <= out_ctrl;
    end
  end

  // R8: a stalled output flit does not change
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data)
                                && $stable(out_ctrl) && $stable(out_tail));

  // R5: inside a burst every flit carries the same source
  p_no_interleave_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid && mid_q |-> out_ctrl == src_q);

endmodule

// File: rtl/burst_xbar.sv
module burst_xbar
  import xbar_pkg::*;
#(
  parameter int NPORT  = 16,
  parameter int DATA_W = 36,
  parameter int CTRL_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NPORT-1:0]        in_valid,
  output logic [NPORT-1:0]        in_ready,
  input  logic [NPORT*DATA_W-1:0] in_data,
  input  logic [NPORT*CTRL_W-1:0] in_ctrl,
  input  logic [NPORT-1:0]        in_tail,
  output logic [NPORT-1:0]        out_valid,
  input  logic [NPORT-1:0]        out_ready,
  output logic [NPORT*DATA_W-1:0] out_data,
  output logic [NPORT*CTRL_W-1:0] out_ctrl,
  output logic [NPORT-1:0]        out_tail
);

  localparam int DEST_W = port_idx_w(NPORT);

  logic [NPORT-1:0]        buf_valid;
  logic [NPORT*DATA_W-1:0] buf_data;
  logic [NPORT-1:0]        buf_tail;
  logic [DEST_W-1:0]       buf_dest  [NPORT];
  logic [NPORT-1:0]        req       [NPORT];
  logic [DEST_W-1:0]       grant_idx [NPORT];
  logic [NPORT-1:0]        grant_ok;
  logic [NPORT-1:0]        take;
  logic [NPORT-1:0]        take_tail;
  logic [NPORT-1:0]        take_from [NPORT];
  logic [NPORT-1:0]        pop;

  // Request matrix: output o sees input i when i's parked flit targets o.
  always_comb begin
    for (int o = 0; o < NPORT; o++)
      for (int i = 0; i < NPORT; i++)
        req[o][i] = buf_valid[i] && (buf_dest[i] == DEST_W'(o));
  end

  // Which outputs are draining each input this cycle.
  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      for (int o = 0; o < NPORT; o++)
        take_from[i][o] = take[o] && (grant_idx[o] == DEST_W'(i));
      pop[i] = |take_from[i];
    end
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    xbar_ingress #(
      .NPORT (NPORT),
      .DATA_W(DATA_W),
      .CTRL_W(CTRL_W),
      .DEST_W(DEST_W)
    ) u_ing (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid[i]),
      .in_data  (in_data[i*DATA_W +: DATA_W]),
      .in_ctrl  (in_ctrl[i*CTRL_W +: CTRL_W]),
      .in_tail  (in_tail[i]),
      .in_ready (in_ready[i]),
      .pop      (pop[i]),
      .buf_valid(buf_valid[i]),
      .buf_data (buf_data[i*DATA_W +: DATA_W]),
      .buf_tail (buf_tail[i]),
      .buf_dest (buf_dest[i])
    );

    // R7: one input feeds at most one output per cycle
    p_single_route_r7: assert property (@(posedge clk) disable iff (rst)
      $onehot0(take_from[i]));
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    xbar_rr_arb #(
      .NPORT (NPORT),
      .DEST_W(DEST_W)
    ) u_arb (
      .clk      (clk),
      .rst      (rst),
      .req      (req[o]),
      .take     (take[o]),
      .take_tail(take_tail[o]),
      .grant_idx(grant_idx[o]),
      .grant_ok (grant_ok[o])
    );

    xbar_egress #(
      .NPORT (NPORT),
      .DATA_W(DATA_W),
      .CTRL_W(CTRL_W),
      .DEST_W(DEST_W)
    ) u_egr (
      .clk      (clk),
      .rst      (rst),
      .src_data (buf_data),
      .src_tail (buf_tail),
      .grant_idx(grant_idx[o]),
      .grant_ok (grant_ok[o]),
      .take     (take[o]),
      .take_tail(take_tail[o]),
      .out_ready(out_ready[o]),
      .out_valid(out_valid[o]),
      .out_data (out_data[o*DATA_W +: DATA_W]),
      .out_ctrl (out_ctrl[o*CTRL_W +: CTRL_W]),
      .out_tail (out_tail[o])
    );
  end

endmodule

// File: tb/sim_burst_xbar.sv
`timescale 1ns/1ps
module sim_burst_xbar;

  localparam int NP    = 4;
  localparam int DW    = 36;
  localparam int CW    = 4;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [NP-1:0]    in_valid, in_ready, in_tail, out_valid, out_ready, out_tail;
  logic [NP*DW-1:0] in_data, out_data;
  logic [NP*CW-1:0] in_ctrl, out_ctrl;

  burst_xbar #(.NPORT(NP), .DATA_W(DW), .CTRL_W(CW)) u0 (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_ctrl(in_ctrl), .in_tail(in_tail),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_ctrl(out_ctrl), .out_tail(out_tail)
  );

  // Stimulus state per input
  logic          pv    [NP];
  logic [DW-1:0] pdata [NP];
  logic [CW-1:0] pctrl [NP];
  logic          ptail [NP];
  int            left  [NP];
  logic [NP-1:0] rdy;

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      in_valid[i]           = pv[i];
      in_data[i*DW +: DW]   = pdata[i];
      in_ctrl[i*CW +: CW]   = pctrl[i];
      in_tail[i]            = ptail[i];
    end
    out_ready = rdy;
  end

  // Behavioural reference: one parked flit per input, one flit per output
  bit            mbv   [NP];
  logic [DW-1:0] mbd   [NP];
  bit            mbt   [NP];
  int            mdst  [NP];
  bit            mlane [NP];
  bit            mov   [NP];
  logic [DW-1:0] mod   [NP];
  int            msrc  [NP];
  bit            mot   [NP];
  bit            mheld [NP];
  int            mown  [NP];
  int            mptr  [NP];

  int    vectors = 0;
  int    fails   = 0;
  int    cyc     = 0;
  bit    hung    = 0;
  int    p_valid, p_ready, max_len, dmode;
  bit    allow_new;
  string tag;

  task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s cycle %0d: actual=%0h expected=%0h", rq, what, cyc, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rdata();
    logic [63:0] t;
    t = {$urandom(), $urandom()};
    return t[DW-1:0];
  endfunction

  function automatic bit idle_all();
    for (int i = 0; i < NP; i++)
      if (mbv[i] || mov[i] || pv[i] || left[i] != 0) return 0;
    return 1;
  endfunction

  task automatic cycle();
    int  g [NP];
    bit  pop [NP];
    bit  er  [NP];
    bit  fired [NP];
    if (cyc > LIMIT) begin hung = 1; return; end
    // drive inputs for this cycle
    for (int i = 0; i < NP; i++) begin
      if (!pv[i] && left[i] > 0 && $urandom_range(99, 0) < p_valid) begin
        left[i]--;
        pv[i] = 1; pdata[i] = rdata(); pctrl[i] = CW'($urandom());
        ptail[i] = (left[i] == 0);
      end else if (!pv[i] && left[i] == 0 && allow_new && $urandom_range(99, 0) < p_valid) begin
        int d;
        int len;
        len = 1 + $urandom_range(max_len - 1, 0);
        d = (dmode == 0) ? $urandom_range(NP - 1, 0) : (dmode == 1) ? (i + 1) % NP : 0;
        left[i] = len - 1;
        pv[i] = 1; pdata[i] = rdata();
        pctrl[i] = CW'(d + NP * $urandom_range(3, 0));
        ptail[i] = (left[i] == 0);
      end
    end
    for (int o = 0; o < NP; o++) rdy[o] = ($urandom_range(99, 0) < p_ready);
    #1;
    // reference grants
    for (int o = 0; o < NP; o++) begin
      int cand;
      cand = -1;
      if (mheld[o]) begin
        if (mbv[mown[o]] && mdst[mown[o]] == o) cand = mown[o];
      end else begin
        for (int k = 0; k < NP; k++) begin
          int idx;
          idx = (mptr[o] + k) % NP;
          if (cand < 0 && mbv[idx] && mdst[idx] == o) cand = idx;
        end
      end
      g[o] = (cand >= 0 && (!mov[o] || rdy[o])) ? cand : -1;
    end
    for (int i = 0; i < NP; i++) begin
      pop[i] = 0;
      for (int o = 0; o < NP; o++) if (g[o] == i) pop[i] = 1;
      er[i] = !mbv[i] || pop[i];
    end
    // compare
    for (int i = 0; i < NP; i++) chk("R8", {tag, " in_ready"}, 64'(in_ready[i]), 64'(er[i]));
    for (int o = 0; o < NP; o++) begin
      chk(tag, "out_valid", 64'(out_valid[o]), 64'(mov[o]));
      if (mov[o]) begin
        chk("R2", {tag, " out_data"}, 64'(out_data[o*DW +: DW]), 64'(mod[o]));
        chk("R3", {tag, " out_ctrl"}, 64'(out_ctrl[o*CW +: CW]), 64'(msrc[o]));
        chk("R5", {tag, " out_tail"}, 64'(out_tail[o]), 64'(mot[o]));
      end
    end
    // reference next state: outputs read the parked flits before they change
    for (int o = 0; o < NP; o++) begin
      if (g[o] >= 0) begin
        mov[o] = 1; mod[o] = mbd[g[o]]; msrc[o] = g[o]; mot[o] = mbt[g[o]];
        if (mbt[g[o]]) begin mheld[o] = 0; mptr[o] = (g[o] + 1) % NP; end
        else begin mheld[o] = 1; mown[o] = g[o]; end
      end else if (rdy[o]) begin
        mov[o] = 0;
      end
    end
    for (int i = 0; i < NP; i++) begin
      fired[i] = pv[i] && er[i];
      if (fired[i]) begin
        mbv[i] = 1; mbd[i] = pdata[i]; mbt[i] = ptail[i];
        if (!mlane[i]) mdst[i] = int'(pctrl[i]) % NP;
        mlane[i] = !ptail[i];
      end else if (pop[i]) begin
        mbv[i] = 0;
      end
    end
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < NP; i++) if (fired[i]) pv[i] = 0;
    cyc++;
  endtask

  task automatic run_phase(string t, int pvl, int prd, int ml, int dm, int n);
    tag = t; p_valid = pvl; p_ready = prd; max_len = ml; dmode = dm; allow_new = 1;
    repeat (n) if (!hung) cycle();
    allow_new = 0; p_valid = 100; p_ready = 100;
    while (!idle_all() && !hung) cycle();
  endtask

  initial begin
    for (int i = 0; i < NP; i++) begin
      pv[i] = 0; pdata[i] = '0; pctrl[i] = '0; ptail[i] = 0; left[i] = 0;
      mbv[i] = 0; mbd[i] = '0; mbt[i] = 0; mdst[i] = 0; mlane[i] = 0;
      mov[i] = 0; mod[i] = '0; msrc[i] = 0; mot[i] = 0;
      mheld[i] = 0; mown[i] = 0; mptr[i] = 0;
    end
    rdy = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    for (int i = 0; i < NP; i++) begin
      chk("R1", "reset out_valid", 64'(out_valid[i]), 64'd0);
      chk("R1", "reset in_ready", 64'(in_ready[i]), 64'd1);
    end
    // R10 single-flit bursts, random targets with random upper control bits
    run_phase("R10", 60, 70, 1, 0, 400);
    // R7 full-rate permutation, no contention
    run_phase("R7", 100, 100, 8, 1, 400);
    // R6 every input aims at output 0
    run_phase("R6", 100, 100, 3, 2, 400);
    // R8 heavy backpressure
    run_phase("R8", 80, 30, 5, 0, 1500);
    // R4 long bursts with junk control on later flits
    run_phase("R4", 70, 60, 6, 0, 1500);
    // R9 mixed random traffic, order per input checked flit by flit
    run_phase("R9", 90, 80, 4, 0, 3000);
    if (hung) begin
      fails++;
      $display("FAIL R8 watchdog: actual=hung expected=drained");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule